// File: doc/BRIEF.md
# Region Vector Tag Array

This block is the tag side of a set-associative cache that tracks memory in 1 KB regions instead of single 64-byte blocks. Each entry stores one region tag and, for every block in that region, a small location field. The field holds a present flag and the data-array way where that block sits. A single probe of one set therefore tells the cache two things: whether any part of the region is on chip, and exactly which blocks are resident and in which data way.

The block accepts one request per cycle and answers in the next cycle. The request kinds are probe, block fill, block drop, region drop and region allocate. Region allocate picks a victim entry in the set: an empty entry first, otherwise the lowest way whose recency bit is clear. When a live region is displaced or dropped, the whole entry (tag, set and location vector) is presented on an eviction port. A downstream evicted-region buffer can then retire the blocks one at a time, so the array never has to evict several blocks in the same cycle. The data array, per-block coherence state and data-block replacement state belong to other blocks.

The address is cut into block offset, block-in-region index, set index and region tag, from low bits to high bits. With the default parameters these are bits [5:0], [9:6], the next SET_W bits, and the remaining high bits. The full-size array (2K sets, SET_W = 11) is a parameter choice. The default keeps the set count small so that the design elaborates quickly.

Top module: `rvt_region_tag_array`

## Requirements
- R1: After reset every entry is empty: rsp_valid and evict_valid are low, and a probe to any set misses with an all-zero vector.
- R2: Every request accepted in cycle k produces rsp_valid high in cycle k+1. A cycle with req_valid low produces rsp_valid and evict_valid low in the next cycle.
- R3: Request codes are probe=0, fill=1, block drop=2, region drop=3 and allocate=4. The region tag is the address above the set index, and the set index sits just above the block-in-region field. rsp_hit is high when a valid entry of the addressed set holds the region tag, and then rsp_way gives that entry's way number.
- R4: rsp_vec holds one field of DWAY_W+1 bits per block. Block i occupies bits [i*(DWAY_W+1) +: DWAY_W+1], the top bit of a field is the present flag, and the low bits are the data way. When rsp_hit is low, rsp_vec is zero.
- R5: A fill (code 1) to a present region writes {1, req_dway} into the field of the block selected by address bits [OFF_W +: BLK_W]. The response shows the updated vector. A fill to an absent region changes nothing and reports a miss.
- R6: A block drop (code 2) to a present region clears the selected field and leaves the other fields unchanged. The response shows the updated vector.
- R7: A region drop (code 3) that hits empties the entry. In the response cycle evict_valid is high with the old tag, set and vector, and rsp_vec shows the old vector. A miss changes nothing and evicts nothing.
- R8: An allocate (code 4) to a present region leaves its vector unchanged, reports a hit with its way and evicts nothing.
- R9: An allocate that misses installs the tag with an all-zero vector. The victim is the lowest-numbered empty way, otherwise the lowest way with its recency bit clear. The response reports rsp_hit=0 and rsp_way equal to the victim.
- R10: Each way of a set has a recency bit. A hit on a probe, fill, block drop or allocate, and every allocate that misses, sets the touched way's bit. If that would set every bit of the set, only the touched way's bit stays set. A region drop leaves the bits alone.
- R11: An allocate whose victim was valid raises evict_valid with the displaced tag, set and vector. An allocate into an empty way raises no eviction.
- R12: Requests in consecutive cycles each see the state left by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code |
| req_addr | input | ADDR_W | Physical address |
| req_dway | input | DWAY_W | Data way for a fill |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Region found in the set |
| rsp_way | output | WAY_IW | Tag-array way of the hit or the victim |
| rsp_vec | output | NBLK*(DWAY_W+1) | Per-block location vector |
| evict_valid | output | 1 | Displaced or dropped entry present |
| evict_tag | output | TAG_W | Tag of the evicted region |
| evict_set | output | SET_W | Set of the evicted region |
| evict_vec | output | NBLK*(DWAY_W+1) | Location vector of the evicted region |

## Verification
The bench builds the array with 4 sets of 3 ways, 4 blocks per region, 4 data ways and a 12-bit address. Three ways is deliberately not a power of two, like the full-size 12, so the victim picker and the recency reset are exercised on an odd way count. At this size every set can be filled beyond capacity, every block field written and cleared, and every way evicted by allocate and by region drop within a few hundred requests. A reference model inside the bench predicts every hit, way, vector and eviction.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
  typedef enum logic [2:0] {
    OP_PROBE   = 3'd0,
    OP_FILL    = 3'd1,
    OP_BLK_DROP = 3'd2,
    OP_REG_DROP = 3'd3,
    OP_ALLOC   = 3'd4
  } rvt_op_e;
endpackage

// File: rtl/rvt_rst_sync.sv
module rvt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/rvt_match.sv
module rvt_match #(
  parameter int WAYS   = 12,
  parameter int TAG_W  = 29,
  parameter int WAY_IW = 4
) (
  input  logic [WAYS-1:0]            ent_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_IW-1:0]          hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = ent_valid[w] && (ent_tag[w] == look_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_IW'(w);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/rvt_victim.sv
module rvt_victim #(
  parameter int WAYS   = 12,
  parameter int WAY_IW = 4
) (
  input  logic [WAYS-1:0]   ent_valid,
  input  logic [WAYS-1:0]   recent,
  output logic [WAY_IW-1:0] victim
);
  logic found_empty;
  logic found_old;
  logic [WAY_IW-1:0] empty_way;
  logic [WAY_IW-1:0] old_way;

  always_comb begin
    found_empty = 1'b0;
    found_old   = 1'b0;
    empty_way   = '0;
    old_way     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found_empty && !ent_valid[w]) begin
        found_empty = 1'b1;
        empty_way   = WAY_IW'(w);
      end
      if (!found_old && !recent[w]) begin
        found_old = 1'b1;
        old_way   = WAY_IW'(w);
      end
    end
    victim = found_empty ? empty_way : old_way;
  end
endmodule

// File: rtl/rvt_plru.sv
module rvt_plru #(
  parameter int WAYS   = 12,
  parameter int WAY_IW = 4
) (
  input  logic [WAYS-1:0]   recent_in,
  input  logic [WAY_IW-1:0] touch_way,
  output logic [WAYS-1:0]   recent_out
);
  logic [WAYS-1:0] touch_bit;
  logic [WAYS-1:0] merged;

  assign touch_bit  = WAYS'(1) << touch_way;
  assign merged     = recent_in | touch_bit;
  assign recent_out = (&merged) ? touch_bit : merged;
endmodule

// File: rtl/rvt_region_tag_array.sv
module rvt_region_tag_array
  import rvt_pkg::*;
#(
  parameter int ADDR_W = 50,
  parameter int OFF_W  = 6,
  parameter int BLK_W  = 4,
  parameter int SET_W  = 4,
  parameter int WAYS   = 12,
  parameter int DWAY_W = 4,
  localparam int TAG_W  = ADDR_W - OFF_W - BLK_W - SET_W,
  localparam int NBLK   = 1 << BLK_W,
  localparam int LOC_W  = DWAY_W + 1,
  localparam int VEC_W  = NBLK * LOC_W,
  localparam int WAY_IW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DWAY_W-1:0] req_dway,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_IW-1:0] rsp_way,
  output logic [VEC_W-1:0]  rsp_vec,
  output logic              evict_valid,
  output logic [TAG_W-1:0]  evict_tag,
  output logic [SET_W-1:0]  evict_set,
  output logic [VEC_W-1:0]  evict_vec
);
  localparam int SETS = 1 << SET_W;

  logic rst_q;
  rvt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // storage
  logic [WAYS-1:0]  valid_q  [SETS];
  logic [WAYS-1:0]  recent_q [SETS];
  logic [TAG_W-1:0] tag_q    [SETS][WAYS];
  logic [VEC_W-1:0] vec_q    [SETS][WAYS];

  // address split
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [BLK_W-1:0] blk_idx;
  logic             unused_off;
  assign set_idx    = req_addr[OFF_W+BLK_W +: SET_W];
  assign tag_in     = req_addr[ADDR_W-1 -: TAG_W];
  assign blk_idx    = req_addr[OFF_W +: BLK_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  // set read
  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0]            rd_recent;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][VEC_W-1:0] rd_vec;

  always_comb begin
    rd_valid  = valid_q[set_idx];
    rd_recent = recent_q[set_idx];
    for (int w = 0; w < WAYS; w++) begin
      rd_tag[w] = tag_q[set_idx][w];
      rd_vec[w] = vec_q[set_idx][w];
    end
  end

  logic [WAYS-1:0]   hit_vec;
  logic              hit;
  logic [WAY_IW-1:0] hit_way;
  logic [WAY_IW-1:0] vic_way;

  rvt_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_IW(WAY_IW)) u_match (
    .ent_valid(rd_valid), .ent_tag(rd_tag), .look_tag(tag_in),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
  );

  rvt_victim #(.WAYS(WAYS), .WAY_IW(WAY_IW)) u_victim (
    .ent_valid(rd_valid), .recent(rd_recent), .victim(vic_way)
  );

  // next-state
  logic              wr_en;
  logic [WAY_IW-1:0] wr_way;
  logic              wr_valid;
  logic [VEC_W-1:0]  wr_vec;
  logic              touch;
  logic [WAY_IW-1:0] touch_way;
  logic [WAYS-1:0]   recent_nxt;
  logic              rsp_hit_n;
  logic [WAY_IW-1:0] rsp_way_n;
  logic [VEC_W-1:0]  rsp_vec_n;
  logic              ev_n;
  logic [TAG_W-1:0]  ev_tag_n;
  logic [VEC_W-1:0]  ev_vec_n;
  logic [VEC_W-1:0]  sel_vec;

  assign sel_vec = rd_vec[hit_way];

  rvt_plru #(.WAYS(WAYS), .WAY_IW(WAY_IW)) u_plru (
    .recent_in(rd_recent), .touch_way(touch_way), .recent_out(recent_nxt)
  );

  always_comb begin
    wr_en     = 1'b0;
    wr_way    = hit_way;
    wr_valid  = 1'b1;
    wr_vec    = sel_vec;
    touch     = 1'b0;
    touch_way = hit_way;
    rsp_hit_n = hit;
    rsp_way_n = hit_way;
    rsp_vec_n = hit ? sel_vec : '0;
    ev_n      = 1'b0;
    ev_tag_n  = tag_in;
    ev_vec_n  = sel_vec;
    if (req_valid) begin
      case (rvt_op_e'(req_op))
        OP_PROBE: touch = hit;
        OP_FILL: if (hit) begin
          wr_en = 1'b1;
          wr_vec[int'(blk_idx)*LOC_W +: LOC_W] = {1'b1, req_dway};
          rsp_vec_n = wr_vec;
          touch = 1'b1;
        end
        OP_BLK_DROP: if (hit) begin
          wr_en = 1'b1;
          wr_vec[int'(blk_idx)*LOC_W +: LOC_W] = '0;
          rsp_vec_n = wr_vec;
          touch = 1'b1;
        end
        OP_REG_DROP: if (hit) begin
          wr_en    = 1'b1;
          wr_valid = 1'b0;
          ev_n     = 1'b1;
        end
        OP_ALLOC: begin
          touch = 1'b1;
          if (!hit) begin
            wr_en     = 1'b1;
            wr_way    = vic_way;
            wr_vec    = '0;
            touch_way = vic_way;
            rsp_way_n = vic_way;
            ev_n      = rd_valid[vic_way];
            ev_tag_n  = rd_tag[vic_way];
            ev_vec_n  = rd_vec[vic_way];
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s]  <= '0;
        recent_q[s] <= '0;
      end
    end else begin
      if (wr_en) valid_q[set_idx][wr_way] <= wr_valid;
      if (touch) recent_q[set_idx] <= recent_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[set_idx][wr_way] <= tag_in;
      vec_q[set_idx][wr_way] <= wr_vec;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_way     <= '0;
      rsp_vec     <= '0;
      evict_valid <= 1'b0;
      evict_tag   <= '0;
      evict_set   <= '0;
      evict_vec   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      evict_valid <= ev_n;
      if (req_valid) begin
        rsp_hit <= rsp_hit_n;
        rsp_way <= rsp_way_n;
        rsp_vec <= rsp_vec_n;
      end
      if (ev_n) begin
        evict_tag <= ev_tag_n;
        evict_set <= set_idx;
        evict_vec <= ev_vec_n;
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> rsp_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> (!rsp_valid && !evict_valid));
  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |-> $onehot0(hit_vec));
  // R4
  miss_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && !rsp_hit) |-> (rsp_vec == '0));
  // R7
  region_drop_evict_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_op == 3'(OP_REG_DROP) && hit) |=> (evict_valid && evict_tag == $past(tag_in)));
  // R8
  alloc_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_op == 3'(OP_ALLOC) && hit) |=> !evict_valid);
  // R11
  evict_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_q)
    evict_valid |-> rsp_valid);
  if (WAYS > 1) begin : g_recent_chk
    // R10
    recent_not_full_chk: assert property (@(posedge clk) disable iff (!rst_q)
      req_valid |-> !(&rd_recent));
  end
endmodule

// File: tb/tb_rvt_region_tag_array.sv
module tb_rvt_region_tag_array;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 2;
  localparam int BLK_W  = 2;
  localparam int SET_W  = 2;
  localparam int WAYS   = 3;
  localparam int DWAY_W = 2;
  localparam int TAG_W  = ADDR_W - OFF_W - BLK_W - SET_W;
  localparam int NBLK   = 1 << BLK_W;
  localparam int LOC_W  = DWAY_W + 1;
  localparam int VEC_W  = NBLK * LOC_W;
  localparam int WAY_IW = 2;
  localparam int SETS   = 1 << SET_W;

  localparam logic [2:0] C_PROBE = 3'd0, C_FILL = 3'd1, C_BDROP = 3'd2,
                         C_RDROP = 3'd3, C_ALLOC = 3'd4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [2:0] req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DWAY_W-1:0] req_dway;
  logic rsp_valid, rsp_hit, evict_valid;
  logic [WAY_IW-1:0] rsp_way;
  logic [VEC_W-1:0] rsp_vec, evict_vec;
  logic [TAG_W-1:0] evict_tag;
  logic [SET_W-1:0] evict_set;

  always #5 clk = ~clk;

  rvt_region_tag_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_W(BLK_W),
    .SET_W(SET_W), .WAYS(WAYS), .DWAY_W(DWAY_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_dway(req_dway), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_vec(rsp_vec),
    .evict_valid(evict_valid), .evict_tag(evict_tag), .evict_set(evict_set),
    .evict_vec(evict_vec));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model
  logic             m_valid [SETS][WAYS];
  logic [TAG_W-1:0] m_tag   [SETS][WAYS];
  logic [VEC_W-1:0] m_vec   [SETS][WAYS];
  logic [WAYS-1:0]  m_rec   [SETS];

  logic e_hit, e_ev;
  int   e_way;
  logic [VEC_W-1:0] e_vec, e_evvec;
  logic [TAG_W-1:0] e_evtag;
  logic [SET_W-1:0] e_evset;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int b);
    return {TAG_W'(t), SET_W'(s), BLK_W'(b), 2'b01};
  endfunction

  task automatic touch(input int s, input int w);
    logic [WAYS-1:0] bit1;
    bit1 = WAYS'(1) << w;
    m_rec[s] = m_rec[s] | bit1;
    if (&m_rec[s]) m_rec[s] = bit1;
  endtask

  task automatic model(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DWAY_W-1:0] dw);
    int s, b, hw, v;
    logic [TAG_W-1:0] t;
    s = int'(a[5:4]); b = int'(a[3:2]); t = a[11:6];
    hw = -1;
    for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
    e_hit = (hw >= 0); e_way = hw; e_ev = 1'b0;
    e_vec = e_hit ? m_vec[s][hw] : '0;
    e_evset = SET_W'(s); e_evtag = t; e_evvec = e_vec;
    case (op)
      C_PROBE: if (e_hit) touch(s, hw);
      C_FILL: if (e_hit) begin
        m_vec[s][hw][b*LOC_W +: LOC_W] = {1'b1, dw};
        e_vec = m_vec[s][hw]; touch(s, hw);
      end
      C_BDROP: if (e_hit) begin
        m_vec[s][hw][b*LOC_W +: LOC_W] = '0;
        e_vec = m_vec[s][hw]; touch(s, hw);
      end
      C_RDROP: if (e_hit) begin
        m_valid[s][hw] = 1'b0; e_ev = 1'b1;
      end
      C_ALLOC: if (e_hit) touch(s, hw);
      else begin
        v = -1;
        for (int w = 0; w < WAYS; w++) if (v < 0 && !m_valid[s][w]) v = w;
        for (int w = 0; w < WAYS; w++) if (v < 0 && !m_rec[s][w]) v = w;
        if (v < 0) v = 0;
        e_way = v; e_ev = m_valid[s][v];
        e_evtag = m_tag[s][v]; e_evvec = m_vec[s][v];
        m_valid[s][v] = 1'b1; m_tag[s][v] = t; m_vec[s][v] = '0;
        touch(s, v);
      end
      default: ;
    endcase
  endtask

  task automatic do_op(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input int dw, input string rq);
    model(op, a, DWAY_W'(dw));
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_dway = DWAY_W'(dw);
    @(posedge clk); #1;
    check(rsp_valid === 1'b1, "R2", "rsp_valid", longint'(rsp_valid), 1);
    check(rsp_hit === e_hit, rq, "hit", longint'(rsp_hit), longint'(e_hit));
    if (e_hit || op == C_ALLOC)
      check(int'(rsp_way) == e_way, rq, "way", longint'(rsp_way), longint'(e_way));
    check(rsp_vec === e_vec, rq, "vec", longint'(rsp_vec), longint'(e_vec));
    check(evict_valid === e_ev, rq, "evict_valid", longint'(evict_valid), longint'(e_ev));
    if (e_ev) begin
      check(evict_tag === e_evtag, rq, "evict_tag", longint'(evict_tag), longint'(e_evtag));
      check(evict_set === e_evset, rq, "evict_set", longint'(evict_set), longint'(e_evset));
      check(evict_vec === e_evvec, rq, "evict_vec", longint'(evict_vec), longint'(e_evvec));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check(rsp_valid === 1'b0 && evict_valid === 1'b0, "R2", "idle outputs",
          longint'({rsp_valid, evict_valid}), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rec[s] = '0;
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 1'b0; m_tag[s][w] = '0; m_vec[s][w] = '0;
      end
    end
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_dway = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    check(rsp_valid === 1'b0 && evict_valid === 1'b0, "R1", "reset outputs",
          longint'({rsp_valid, evict_valid}), 0);
    for (int s = 0; s < SETS; s++) do_op(C_PROBE, mk(5, s, 0), 0, "R1");
    idle();
    // R9 R11 allocate past capacity
    for (int s = 0; s < SETS; s++)
      for (int t = 1; t <= 4; t++) do_op(C_ALLOC, mk(t, s, 0), 0, "R9_R11");
    // R5 fill every block, present and absent regions
    for (int s = 0; s < SETS; s++)
      for (int t = 1; t <= 4; t++)
        for (int b = 0; b < NBLK; b++) do_op(C_FILL, mk(t, s, b), (t + b + s) % 4, "R5");
    // R4 R12 probes of everything
    for (int s = 0; s < SETS; s++)
      for (int t = 1; t <= 4; t++) do_op(C_PROBE, mk(t, s, 0), 0, "R4_R12");
    // R6 drop odd blocks
    for (int s = 0; s < SETS; s++)
      for (int t = 1; t <= 4; t++)
        for (int b = 1; b < NBLK; b += 2) do_op(C_BDROP, mk(t, s, b), 0, "R6");
    idle();
    // R8 allocate of present regions (absent ones evict again, R11)
    for (int s = 0; s < SETS; s++)
      for (int t = 1; t <= 4; t++) do_op(C_ALLOC, mk(t, s, 0), 0, "R8");
    // R7 region drops, then allocate takes the empty way (R9)
    for (int s = 0; s < SETS; s++) begin
      for (int t = 1; t <= 4; t++) do_op(C_RDROP, mk(t, s, 0), 0, "R7");
      do_op(C_RDROP, mk(9, s, 0), 0, "R7");
      do_op(C_ALLOC, mk(7, s, 0), 0, "R9");
      do_op(C_PROBE, mk(7, s, 0), 0, "R9");
    end
    // R10 recency: mixed probes and allocates in set 1
    for (int k = 10; k < 40; k++) begin
      do_op(C_PROBE, mk(k - 2, 1, 0), 0, "R10");
      do_op(C_FILL, mk(k - 1, 1, k % 4), k % 4, "R10");
      do_op(C_ALLOC, mk(k, 1, 0), 0, "R10");
    end
    idle();
    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule